// File: doc/BRIEF.md
# Software Write-Protect Sequence Detector

This block sits on the write path of a byte-wide nonvolatile memory, between the bus interface and the page-write engine. Every write cycle is presented as a single-cycle valid pulse carrying a 15-bit address and a data byte. The block matches these writes against two key sequences. The first is a three-write unlock prefix that must come before any programming write while protection is on. The second is a six-write disable command. The block keeps the protection flag and decides for each write whether it is forwarded as a programming write, consumed as a command step, or dropped.

A programming write that follows the unlock prefix turns protection on. The prefix on its own leaves the flag unchanged. After that, only one write per prefix gets through. The disable command clears the flag, and none of its six writes reaches the array. While the memory reports that it is busy programming, incoming writes are ignored entirely. All outputs are registered and appear one clock after the write cycle that caused them.

Top module: `swp_guard`

## Requirements
- R1: After reset, and after any later reset, `prot_on`, `wr_accept` and `cmd_consumed` are 0 and protection is off.
- R2: With protection off, a write that is not a key step produces `wr_accept` for one cycle on the clock after the write, with `acc_addr`/`acc_data` equal to the written address and data.
- R3: A write that advances a key sequence produces `cmd_consumed` one clock later and never `wr_accept`. The steps are data AAh at 5555h, then 55h at 2AAAh, then either A0h at 5555h (unlock) or 80h at 5555h followed by AAh at 5555h, 55h at 2AAAh and 20h at 5555h (disable).
- R4: The first write after a completed unlock prefix (AAh@5555h, 55h@2AAAh, A0h@5555h) is accepted, whatever its address and data, and `prot_on` is 1 from the same cycle as that `wr_accept`.
- R5: The unlock prefix without a following write does not set `prot_on`.
- R6: With protection on, a write that does not follow the unlock prefix and is not a key step produces neither `wr_accept` nor `cmd_consumed`.
- R7: With protection on, exactly one write is accepted per unlock prefix; the write after it is dropped.
- R8: Completing the six-write disable command clears `prot_on` in the same cycle as the `cmd_consumed` of its last step, and none of the six writes is accepted.
- R9: A write that does not match the expected next step returns the matcher to idle and is handled as an ordinary write (accepted if protection is off, dropped if on); if that write is AAh@5555h it is consumed and starts a new sequence.
- R10: Key addresses are compared on all 15 address bits; 55h written to 6AAAh does not count as the 2AAAh step.
- R11: A write presented while `prog_busy` is 1 produces no output pulse and leaves the matcher position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle write cycle strobe |
| wr_addr | input | 15 | Write address |
| wr_data | input | 8 | Write data |
| prog_busy | input | 1 | Memory is running an internal programming cycle |
| prot_on | output | 1 | Software write protection enabled |
| wr_accept | output | 1 | Write forwarded to the page-write engine (one cycle) |
| acc_addr | output | 15 | Address of the forwarded write |
| acc_data | output | 8 | Data of the forwarded write |
| cmd_consumed | output | 1 | Write absorbed as a key sequence step (one cycle) |

## Verification
The bench targets a repeated AAh@5555h in the middle of a sequence. A matcher that only drops to idle would then lose the restart and would treat the next 55h@2AAAh as an ordinary write. It also writes 55h to an address that differs from the key only in bit 14. A design that compares a truncated address would wrongly advance on that write. A second write after a single prefix must be dropped, which exposes a design that leaves the unlock open. A key step sent while the memory is busy must not move the matcher, or the disable command that follows would fail or complete early.

// File: rtl/swp_pkg.sv
package swp_pkg;

  localparam int NKEYS = 5;
  localparam int K_AA  = 0;
  localparam int K_55  = 1;
  localparam int K_A0  = 2;
  localparam int K_80  = 3;
  localparam int K_20  = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K1   = 3'd1,
    ST_K2   = 3'd2,
    ST_ARM  = 3'd3,
    ST_K3   = 3'd4,
    ST_K4   = 3'd5,
    ST_K5   = 3'd6
  } swp_step_e;

  typedef struct packed {
    swp_step_e nxt;
    logic      cmd;
    logic      arm;
    logic      plain;
    logic      off;
  } swp_act_t;

  // Data byte of each key step
  function automatic logic [7:0] key_data(input int k);
    case (k)
      K_AA:    key_data = 8'hAA;
      K_55:    key_data = 8'h55;
      K_A0:    key_data = 8'hA0;
      K_80:    key_data = 8'h80;
      default: key_data = 8'h20;
    endcase
  endfunction

  // 1: key step sits at the first key address, 0: at the second
  function automatic logic key_at_first(input int k);
    key_at_first = (k != K_55);
  endfunction

  // Next matcher position and classification of one write
  function automatic swp_act_t step_next(input swp_step_e cur,
                                         input logic [NKEYS-1:0] hit);
    swp_act_t a;
    a.nxt   = hit[K_AA] ? ST_K1 : ST_IDLE;
    a.cmd   = hit[K_AA];
    a.plain = !hit[K_AA];
    a.arm   = 1'b0;
    a.off   = 1'b0;
    case (cur)
      ST_K1: if (hit[K_55]) begin a.nxt = ST_K2; a.cmd = 1'b1; a.plain = 1'b0; end
      ST_K2: begin
        if (hit[K_A0]) begin a.nxt = ST_ARM; a.cmd = 1'b1; a.plain = 1'b0; end
        else if (hit[K_80]) begin a.nxt = ST_K3; a.cmd = 1'b1; a.plain = 1'b0; end
      end
      ST_ARM: begin
        a.nxt = ST_IDLE; a.cmd = 1'b0; a.plain = 1'b0; a.arm = 1'b1;
      end
      ST_K3: if (hit[K_AA]) begin a.nxt = ST_K4; a.cmd = 1'b1; a.plain = 1'b0; end
      ST_K4: if (hit[K_55]) begin a.nxt = ST_K5; a.cmd = 1'b1; a.plain = 1'b0; end
      ST_K5: if (hit[K_20]) begin
        a.nxt = ST_IDLE; a.cmd = 1'b1; a.plain = 1'b0; a.off = 1'b1;
      end
      default: ;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/swp_key_match.sv
module swp_key_match
  import swp_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 15'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 15'h2AAA
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [NKEYS-1:0]  hit
);

  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    localparam logic [ADDR_W-1:0] KA = key_at_first(k) ? KEY_ADDR_A : KEY_ADDR_B;
    localparam logic [DATA_W-1:0] KD = DATA_W'(key_data(k));
    assign hit[k] = (addr == KA) && (data == KD);
  end

endmodule

// File: rtl/swp_seq_fsm.sv
module swp_seq_fsm
  import swp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev,
  input  logic [NKEYS-1:0] hit,
  output swp_step_e        step_q,
  output logic             ev_cmd,
  output logic             ev_arm,
  output logic             ev_plain,
  output logic             ev_off
);

  swp_act_t act;

  always_comb act = step_next(step_q, hit);

  assign ev_cmd   = ev & act.cmd;
  assign ev_arm   = ev & act.arm;
  assign ev_plain = ev & act.plain;
  assign ev_off   = ev & act.off;

  always_ff @(posedge clk) begin
    if (!rst_n)  step_q <= ST_IDLE;
    else if (ev) step_q <= act.nxt;
  end

  // R3: key-step decoders never report two steps for one write
  a_r3_hits_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  // R7: an armed matcher lets one write through and then leaves the armed state
  a_r7_arm_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && step_q == ST_ARM) |=> (step_q != ST_ARM));

  // R9: an idle matcher only leaves idle on the first key step
  a_r9_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && step_q == ST_IDLE && !hit[K_AA]) |=> (step_q == ST_IDLE));

endmodule

// File: rtl/swp_out_gate.sv
module swp_out_gate #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_cmd,
  input  logic              ev_arm,
  input  logic              ev_plain,
  input  logic              ev_off,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              prot_on,
  output logic              wr_accept,
  output logic              cmd_consumed,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_data
);

  logic pass_d;
  assign pass_d = ev_arm | (ev_plain & ~prot_on);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_on      <= 1'b0;
      wr_accept    <= 1'b0;
      cmd_consumed <= 1'b0;
      acc_addr     <= '0;
      acc_data     <= '0;
    end else begin
      wr_accept    <= pass_d;
      cmd_consumed <= ev_cmd;
      if (ev_arm)      prot_on <= 1'b1;
      else if (ev_off) prot_on <= 1'b0;
      if (pass_d) begin
        acc_addr <= addr;
        acc_data <= data;
      end
    end
  end

  // R3: a write is never both forwarded and consumed
  a_r3_accept_or_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_accept && cmd_consumed));

  // R4: protection only switches on together with the forwarded write
  a_r4_rise_with_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> wr_accept);

  // R8: protection only switches off on the last disable step
  a_r8_fall_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> cmd_consumed);

  // R6: an unprefixed write under protection leaves no trace
  a_r6_drop_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_plain && prot_on) |=> (!wr_accept && !cmd_consumed));

endmodule

// File: rtl/swp_guard.sv
module swp_guard
  import swp_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 15'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 15'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_busy,
  output logic              prot_on,
  output logic              wr_accept,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_data,
  output logic              cmd_consumed
);

  logic             ev;
  logic [NKEYS-1:0] hit;
  swp_step_e        step_q;
  logic             ev_cmd, ev_arm, ev_plain, ev_off;

  assign ev = wr_valid & ~prog_busy;

  swp_key_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_ADDR_A(KEY_ADDR_A), .KEY_ADDR_B(KEY_ADDR_B)
  ) u_match (
    .addr(wr_addr), .data(wr_data), .hit(hit)
  );

  swp_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ev(ev), .hit(hit), .step_q(step_q),
    .ev_cmd(ev_cmd), .ev_arm(ev_arm), .ev_plain(ev_plain), .ev_off(ev_off)
  );

  swp_out_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .ev_cmd(ev_cmd), .ev_arm(ev_arm), .ev_plain(ev_plain), .ev_off(ev_off),
    .addr(wr_addr), .data(wr_data),
    .prot_on(prot_on), .wr_accept(wr_accept), .cmd_consumed(cmd_consumed),
    .acc_addr(acc_addr), .acc_data(acc_data)
  );

  // R11: a write during programming moves nothing
  a_r11_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && prog_busy) |=> (!wr_accept && !cmd_consumed && $stable(step_q)
                                 && $stable(prot_on)));

endmodule

// File: tb/test_swp_guard.sv
module test_swp_guard;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 25;

  // {tag, addr, data, busy, exp_accept, exp_cmd, exp_prot}
  localparam logic [42:0] VEC [NV] = '{
    {"R2",  15'h1234, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b0},
    {"R3",  15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, 1'b0},
    {"R3",  15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1, 1'b0},
    {"R5",  15'h5555, 8'hA0, 1'b0, 1'b0, 1'b1, 1'b0},
    {"R4",  15'h0100, 8'hC3, 1'b0, 1'b1, 1'b0, 1'b1},
    {"R6",  15'h0101, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b1},
    {"R3",  15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, 1'b1},
    {"R3",  15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1, 1'b1},
    {"R3",  15'h5555, 8'hA0, 1'b0, 1'b0, 1'b1, 1'b1},
    {"R7",  15'h0200, 8'h77, 1'b0, 1'b1, 1'b0, 1'b1},
    {"R7",  15'h0201, 8'h88, 1'b0, 1'b0, 1'b0, 1'b1},
    {"R3",  15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, 1'b1},
    {"R10", 15'h6AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1},
    {"R3",  15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, 1'b1},
    {"R9",  15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, 1'b1},
    {"R9",  15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1, 1'b1},
    {"R8",  15'h5555, 8'h80, 1'b0, 1'b0, 1'b1, 1'b1},
    {"R8",  15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, 1'b1},
    {"R11", 15'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0, 1'b1},
    {"R8",  15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1, 1'b1},
    {"R8",  15'h5555, 8'h20, 1'b0, 1'b0, 1'b1, 1'b0},
    {"R3",  15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, 1'b0},
    {"R9",  15'h0300, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0},
    {"R11", 15'h0400, 8'h22, 1'b1, 1'b0, 1'b0, 1'b0},
    {"R2",  15'h4444, 8'h99, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        prog_busy = 1'b0;
  logic        prot_on, wr_accept, cmd_consumed;
  logic [14:0] acc_addr;
  logic [7:0]  acc_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swp_guard i_swp_guard (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_busy(prog_busy), .prot_on(prot_on),
    .wr_accept(wr_accept), .acc_addr(acc_addr), .acc_data(acc_data),
    .cmd_consumed(cmd_consumed)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one-cycle write; outputs sampled at the following falling edge
  task automatic put(input logic [14:0] a, input logic [7:0] d, input logic b);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; prog_busy = b;
    @(negedge clk);
    wr_valid = 1'b0; prog_busy = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", "prot_on", 32'(prot_on), 32'd0);
    chk("R1", "wr_accept", 32'(wr_accept), 32'd0);
    chk("R1", "cmd_consumed", 32'(cmd_consumed), 32'd0);

    for (int i = 0; i < NV; i++) begin
      string t;
      t = string'(VEC[i][42:27]);
      put(VEC[i][26:12], VEC[i][11:4], VEC[i][3]);
      chk(t, "wr_accept", 32'(wr_accept), 32'(VEC[i][2]));
      chk(t, "cmd_consumed", 32'(cmd_consumed), 32'(VEC[i][1]));
      chk(t, "prot_on", 32'(prot_on), 32'(VEC[i][0]));
      if (VEC[i][2]) begin
        chk(t, "acc_addr", 32'(acc_addr), 32'(VEC[i][26:12]));
        chk(t, "acc_data", 32'(acc_data), 32'(VEC[i][11:4]));
      end
    end

    // R4: the armed write may itself look like a key step
    put(15'h5555, 8'hAA, 1'b0);
    put(15'h2AAA, 8'h55, 1'b0);
    put(15'h5555, 8'hA0, 1'b0);
    put(15'h5555, 8'hAA, 1'b0);
    chk("R4", "wr_accept", 32'(wr_accept), 32'd1);
    chk("R4", "cmd_consumed", 32'(cmd_consumed), 32'd0);
    chk("R4", "prot_on", 32'(prot_on), 32'd1);
    chk("R4", "acc_data", 32'(acc_data), 32'hAA);

    // R1: a later reset clears protection
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "prot_on after reset", 32'(prot_on), 32'd0);
    put(15'h0010, 8'h42, 1'b0);
    chk("R1", "wr_accept after reset", 32'(wr_accept), 32'd1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule